// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Coherent Halfword Read

A single timer channel built on a 32-bit down-counter that sits on a 16-bit register bus. The counter steps down by one whenever the count source chosen in the control register fires. There are three kinds of source: a tap of a free-running divider on the system clock, a tick from an always-on slow clock, and rising edges of an external clock pin, which are resynchronised into the system clock domain.

When the counter steps past zero, it takes the value of a constant register in that same cycle and keeps counting from there. The same step raises a sticky underflow flag. That flag, together with an enable bit, drives an interrupt line.

A 16-bit bus cannot move all 32 bits of the counter at once, so the two halves would normally be read at different instants. To avoid a torn value, reading the low half copies the whole counter into a shadow latch. A read of the high half that follows returns the upper bits from that same instant.

Top module: `rld_timer`

## Requirements
- R1: After reset, the counter and the constant register both read 0xFFFFFFFF and the control register reads 0x0000.
- R2: While the run bit (control bit 3) is 1, the counter decreases by exactly one on each tick of the selected source. Writing halfword index 1 replaces bits 15:0 of the counter and writing index 2 replaces bits 31:16.
- R3: Source codes 0 to 4 (control bits 2:0) tick once per 4, 16, 64, 256 and 1024 system clocks respectively. Any run of 4^(k+1) consecutive clocks contains exactly one tick for code k.
- R4: Source code 5 counts one step per clock in which the always-on tick input is high. Codes 6 and 7 count one step per rising edge of the external clock input, after two synchroniser flops.
- R5: A tick while the counter holds 0 loads the constant register (index 3 = low half, index 4 = high half) into the counter at that same edge and sets the underflow flag (control bit 8).
- R6: Writing the control register with bit 8 = 0 clears the underflow flag and writing bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R7: A software write to the counter in the same cycle as an underflow takes priority over the reload, and the underflow flag is still set.
- R8: Reading index 1 returns the live counter bits 15:0 and captures all 32 bits into the shadow latch. Reading index 2 returns bits 31:16 of the shadow latch, not of the live counter.
- R9: While the hold input is high, the counter keeps its value for source codes 0 to 4, 6 and 7. With code 5 it keeps counting.
- R10: The interrupt output is high exactly when the underflow flag and the interrupt-enable bit (control bit 4) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Standby hold condition |
| aon_tick_i | input | 1 | Always-on slow clock tick, one system clock wide |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| bus_re_i | input | 1 | Read strobe |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Halfword register index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Underflow interrupt request |

## Verification
The assertions assume that read and write strobes are never raised together. They also assume that the always-on tick and the external clock change only away from the rising edge of the system clock, and that the external clock stays high and low for at least two system clocks so the synchroniser can see every edge. The stimulus drives every input at the falling edge and holds each external clock phase for two clocks. It also issues bus accesses one at a time, so these assumptions always hold. Divider checks use windows that are exact multiples of the division ratio, which makes the expected step count independent of the divider phase.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_CNT_LO = 3'd1,
      RA_CNT_HI = 3'd2,
      RA_CST_LO = 3'd3,
      RA_CST_HI = 3'd4
   } reg_addr_e;

   localparam int CB_RUN = 3;
   localparam int CB_IE  = 4;
   localparam int CB_UF  = 8;
   localparam logic [2:0] SRC_AON = 3'd5;

endpackage

// File: rtl/rld_timer_presc.sv
module rld_timer_presc
   import rld_timer_pkg::*;
#(
   parameter int PRE_STEPS = 5,
   parameter int PRE_SHIFT = 2,
   parameter int SYNC_LEN  = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] src_i,
   input  logic       run_i,
   input  logic       hold_i,
   input  logic       aon_tick_i,
   input  logic       ext_clk_i,
   output logic       cnt_en_o
);
   localparam int PRE_W = PRE_STEPS * PRE_SHIFT;

   if (PRE_STEPS < 1 || PRE_STEPS > 5) begin : g_bad_steps
      $error("PRE_STEPS must be 1..5");
   end
   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("SYNC_LEN must be at least 2");
   end

   logic [PRE_W-1:0]     div_q;
   logic [PRE_STEPS-1:0] div_tick;
   logic [SYNC_LEN:0]    ext_q;
   logic                 ext_rise;
   logic                 tick;
   logic                 keep;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < PRE_STEPS; i++) begin : g_tap
      assign div_tick[i] = &div_q[PRE_SHIFT*(i+1)-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ext_q <= '0;
      else         ext_q <= {ext_q[SYNC_LEN-1:0], ext_clk_i};
   end
   assign ext_rise = ext_q[SYNC_LEN-1] & ~ext_q[SYNC_LEN];

   always_comb begin
      tick = 1'b0;
      if (src_i == SRC_AON)      tick = aon_tick_i;
      else if (src_i > SRC_AON)  tick = ext_rise;
      else begin
         for (int i = 0; i < PRE_STEPS; i++)
            if (src_i == i[2:0]) tick = div_tick[i];
      end
   end

   assign keep     = hold_i && (src_i != SRC_AON);
   assign cnt_en_o = run_i && tick && !keep;

   AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && src_i != SRC_AON) |-> !cnt_en_o);                       // R9
   AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_tick[0] |=> !div_tick[0]);                                      // R3
   AST_EXT_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_rise |=> !ext_rise);                                            // R4

endmodule

// File: rtl/rld_timer_core.sv
module rld_timer_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [CNT_W/2-1:0] wdata_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uf_o
);
   localparam int HW = CNT_W / 2;

   if (CNT_W % 2 != 0) begin : g_bad_width
      $error("CNT_W must be even");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '1;
      end else if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) cnt_q[HW-1:0]     <= wdata_i;
         if (wr_hi_i) cnt_q[CNT_W-1:HW] <= wdata_i;
      end else if (en_i) begin
         cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign uf_o  = en_i && at_zero;

   AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !at_zero && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
   AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && at_zero && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(reload_i));       // R5
   AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uf_o && wr_lo_i && !wr_hi_i) |=> cnt_q[HW-1:0] == $past(wdata_i));           // R7
   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));                          // R2

endmodule

// File: rtl/rld_timer.sv
module rld_timer
   import rld_timer_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int PRE_STEPS = 5,
   parameter int PRE_SHIFT = 2,
   parameter int SYNC_LEN  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic             aon_tick_i,
   input  logic             ext_clk_i,
   input  logic             bus_re_i,
   input  logic             bus_we_i,
   input  logic [2:0]       bus_addr_i,
   input  logic [BUS_W-1:0] bus_wdata_i,
   output logic [BUS_W-1:0] bus_rdata_o,
   output logic             irq_o
);
   localparam int CNT_W = 2 * BUS_W;

   if (BUS_W <= CB_UF) begin : g_bad_bus
      $error("BUS_W too narrow for the control layout");
   end

   logic [2:0]       src_q;
   logic             run_q, ie_q, uf_q;
   logic [CNT_W-1:0] cst_q, shadow_q, cnt;
   logic             cnt_en, uf_evt;
   logic             ctrl_wr, uf_clr, lo_rd;
   logic             unused_wbits;

   assign ctrl_wr = bus_we_i && bus_addr_i == RA_CTRL;
   assign uf_clr  = ctrl_wr && !bus_wdata_i[CB_UF];
   assign lo_rd   = bus_re_i && bus_addr_i == RA_CNT_LO;
   assign unused_wbits = ^{bus_wdata_i[BUS_W-1:CB_UF+1], bus_wdata_i[CB_UF-1:CB_IE+1]};

   rld_timer_presc #(
      .PRE_STEPS (PRE_STEPS),
      .PRE_SHIFT (PRE_SHIFT),
      .SYNC_LEN  (SYNC_LEN)
   ) u_presc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_q),
      .run_i      (run_q),
      .hold_i     (hold_i),
      .aon_tick_i (aon_tick_i),
      .ext_clk_i  (ext_clk_i),
      .cnt_en_o   (cnt_en)
   );

   rld_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (cnt_en),
      .wr_lo_i  (bus_we_i && bus_addr_i == RA_CNT_LO),
      .wr_hi_i  (bus_we_i && bus_addr_i == RA_CNT_HI),
      .wdata_i  (bus_wdata_i),
      .reload_i (cst_q),
      .cnt_o    (cnt),
      .uf_o     (uf_evt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         src_q <= '0;
         run_q <= 1'b0;
         ie_q  <= 1'b0;
      end else if (ctrl_wr) begin
         src_q <= bus_wdata_i[2:0];
         run_q <= bus_wdata_i[CB_RUN];
         ie_q  <= bus_wdata_i[CB_IE];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     uf_q <= 1'b0;
      else if (uf_evt) uf_q <= 1'b1;
      else if (uf_clr) uf_q <= 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cst_q <= '1;
      end else if (bus_we_i) begin
         if (bus_addr_i == RA_CST_LO) cst_q[BUS_W-1:0]     <= bus_wdata_i;
         if (bus_addr_i == RA_CST_HI) cst_q[CNT_W-1:BUS_W] <= bus_wdata_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    shadow_q <= '1;
      else if (lo_rd) shadow_q <= cnt;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_re_i) begin
         case (bus_addr_i)
            RA_CTRL: begin
               bus_rdata_o[2:0]    = src_q;
               bus_rdata_o[CB_RUN] = run_q;
               bus_rdata_o[CB_IE]  = ie_q;
               bus_rdata_o[CB_UF]  = uf_q;
            end
            RA_CNT_LO: bus_rdata_o = cnt[BUS_W-1:0];
            RA_CNT_HI: bus_rdata_o = shadow_q[CNT_W-1:BUS_W];
            RA_CST_LO: bus_rdata_o = cst_q[BUS_W-1:0];
            RA_CST_HI: bus_rdata_o = cst_q[CNT_W-1:BUS_W];
            default:   bus_rdata_o = '0;
         endcase
      end
   end

   assign irq_o = uf_q && ie_q;

   AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_rd |=> shadow_q == $past(cnt));                                   // R8
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uf_q && !uf_clr) |=> uf_q);                                          // R6
   AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uf_evt |=> uf_q);                                                     // R5
   AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uf_evt && ie_q && !ctrl_wr) |=> irq_o);                              // R10
   AST_NO_RW_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_re_i && bus_we_i));                                             // R8

endmodule

// File: tb/tb_rld_timer.sv
`timescale 1ns/1ps
module tb_rld_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0, aon = 1'b0, ext = 1'b0;
   logic        re = 1'b0, we = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   logic [15:0] exp_q[$];
   logic [15:0] act_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   rld_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .aon_tick_i(aon),
      .ext_clk_i(ext), .bus_re_i(re), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2,
                          A_KLO = 3'd3, A_KHI = 3'd4;

   // monitor: pops expected items and compares with what the design produced
   initial begin
      forever begin
         wait (act_q.size() > 0);
         begin
            logic [15:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s: actual 0x%04h expected 0x%04h", t, a, e);
            end
         end
      end
   end

   // drivers: called at a falling edge, return at the next falling edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
      re = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      #1 act_q.push_back(rdata);
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      exp_q.push_back({15'b0, e}); tag_q.push_back(t);
      act_q.push_back({15'b0, irq});
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext = 1'b1; idle(2);
         ext = 1'b0; idle(2);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1 reset values, R10 no interrupt
      rd(A_CTRL, 16'h0000, "R1 ctrl");
      rd(A_CLO,  16'hFFFF, "R1 cnt lo");
      rd(A_CHI,  16'hFFFF, "R1 cnt hi");
      rd(A_KLO,  16'hFFFF, "R1 const lo");
      rd(A_KHI,  16'hFFFF, "R1 const hi");
      chk_irq(1'b0, "R10 reset irq");

      // R2 software write of both halves
      wr(A_CHI, 16'h1234);
      wr(A_CLO, 16'h5678);
      rd(A_CLO, 16'h5678, "R2 write lo");
      rd(A_CHI, 16'h1234, "R2 write hi");

      // R3 dividers: windows of exact multiples
      wr(A_CTRL, 16'h0008); idle(63); wr(A_CTRL, 16'h0000);
      rd(A_CLO, 16'h5668, "R3 div4");
      wr(A_CTRL, 16'h0009); idle(255); wr(A_CTRL, 16'h0001);
      rd(A_CLO, 16'h5658, "R3 div16");
      wr(A_CTRL, 16'h000C); idle(2047); wr(A_CTRL, 16'h0004);
      rd(A_CLO, 16'h5656, "R3 div1024");
      rd(A_CHI, 16'h1234, "R2 hi untouched");

      // R4 always-on tick and external edges
      aon = 1'b1;
      wr(A_CTRL, 16'h000D); idle(9); wr(A_CTRL, 16'h0005);
      aon = 1'b0;
      rd(A_CLO, 16'h564C, "R4 aon");
      wr(A_CTRL, 16'h000E); ext_pulses(4); idle(4); wr(A_CTRL, 16'h0006);
      rd(A_CLO, 16'h5648, "R4 ext edges");
      wr(A_CTRL, 16'h000F); ext_pulses(3); idle(4); wr(A_CTRL, 16'h0007);
      rd(A_CLO, 16'h5645, "R4 ext code7");

      // R8 coherent read across a halfword borrow
      wr(A_CHI, 16'h0001);
      wr(A_CLO, 16'h0002);
      aon = 1'b1;
      wr(A_CTRL, 16'h000D);
      rd(A_CLO, 16'h0002, "R8 live lo");
      idle(5);
      rd(A_CHI, 16'h0001, "R8 latched hi");
      wr(A_CTRL, 16'h0005);
      aon = 1'b0;
      rd(A_CLO, 16'hFFFA, "R8 relatch lo");
      rd(A_CHI, 16'h0000, "R8 relatch hi");

      // R5 reload on underflow, R6 set beats clear, R10 interrupt
      wr(A_KHI, 16'h0000);
      wr(A_KLO, 16'h0005);
      wr(A_CLO, 16'h0001);
      aon = 1'b1;
      wr(A_CTRL, 16'h001D); idle(1); wr(A_CTRL, 16'h0015);
      aon = 1'b0;
      rd(A_CLO, 16'h0005, "R5 reload");
      rd(A_CTRL, 16'h0115, "R6 set wins over clear");
      chk_irq(1'b1, "R10 irq high");
      wr(A_CTRL, 16'h0115);
      rd(A_CTRL, 16'h0115, "R6 write one keeps");
      wr(A_CTRL, 16'h0015);
      rd(A_CTRL, 16'h0015, "R6 write zero clears");
      chk_irq(1'b0, "R10 irq low");
      wr(A_CTRL, 16'h0005);

      // R7 write at the underflow edge wins, flag still sets
      wr(A_CLO, 16'h0001);
      aon = 1'b1;
      wr(A_CTRL, 16'h000D); idle(1); wr(A_CLO, 16'h00AA); wr(A_CTRL, 16'h0105);
      aon = 1'b0;
      rd(A_CLO, 16'h00A9, "R7 write wins");
      rd(A_CTRL, 16'h0105, "R7 flag set");
      chk_irq(1'b0, "R10 ie off");
      wr(A_CTRL, 16'h0005);

      // R9 hold
      wr(A_CLO, 16'h0100);
      hold = 1'b1;
      wr(A_CTRL, 16'h0008); idle(99); wr(A_CTRL, 16'h0000);
      rd(A_CLO, 16'h0100, "R9 hold divider");
      wr(A_CTRL, 16'h000E); ext_pulses(3); idle(4); wr(A_CTRL, 16'h0006);
      rd(A_CLO, 16'h0100, "R9 hold external");
      aon = 1'b1;
      wr(A_CTRL, 16'h000D); idle(9); wr(A_CTRL, 16'h0005);
      aon = 1'b0;
      hold = 1'b0;
      rd(A_CLO, 16'h00F6, "R9 aon keeps counting");

      wait (act_q.size() == 0);
      #1;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule